// File: doc/BRIEF.md
# Privileged Control Register Access Router

This block decides, in a single combinational step, what happens when software reads or writes one banked interrupt-interface control register. The inputs are the privilege level of the access (0 to 3), which higher levels are present, the trap and enable bits that those levels configure, and the current security state. From these the block selects exactly one outcome. The access can be undefined, it can trap to the hypervisor level with syndrome code 0x03, or it can trap to the monitor level. Otherwise it goes to one of four register copies: virtual, non-secure physical, secure physical, or the single physical copy used when no monitor level exists.

The block also holds the four register copies. A read returns the selected copy. A write updates that copy in the next clock edge. In each copy only the two control bits are writable. The remaining bits are a fixed feature description that ignores writes. Taking the exception itself and formatting the syndrome are left to the surrounding logic.

Top module: `ctl_access_router`

## Requirements
- R1: An access made at privilege level 0 always gives the undefined outcome.
- R2: `outcome` is one-hot for every input combination. Bit 0 is undefined, bit 1 is the hypervisor trap, bit 2 is the monitor trap, bit 3 is the virtual copy, bit 4 is the non-secure copy, bit 5 is the secure copy and bit 6 is the single copy.
- R3: At levels 1 and 2, the first check is: monitor level present, `undefPrio` high, and both `irqRoute` and `fiqRoute` high. When it holds, the outcome is undefined.
- R4: At level 1, after R3, `hypT12` with `lvl2En` high gives the hypervisor trap. This check comes before the level-1 enable check.
- R5: At level 1, after R4, a low `sreL1` gives undefined. After that, `hypTc` with `lvl2En` gives the hypervisor trap.
- R6: At level 1, after R5, `hypFiqVirt` or `hypIrqVirt` with `lvl2En` high routes the access to the virtual copy.
- R7: At levels 1 and 2, after the earlier checks, a present monitor level with both route bits high gives undefined when `undefLate` is high, and the monitor trap otherwise.
- R8: When no earlier rule applies at level 1 or 2, the access goes to the non-secure copy if the monitor level is present, and to the single copy if it is not.
- R9: At level 2, a low `sreL2` gives undefined. This check comes after R3 and before R7. The level-2 path ignores the T12, TC, FMO and IMO bits and `sreL1`.
- R10: At level 3, a low `sreL3` gives undefined. Otherwise `nsState` = 0 selects the secure copy and `nsState` = 1 selects the non-secure copy.
- R11: `trapCode` is 0x03 when the outcome is the hypervisor trap, and 0 otherwise.
- R12: `rdData` shows the selected copy when the outcome is a copy access, and 0 otherwise. Bits 31:2 of every copy read as FEATURES[31:2]. Bits 1:0 reset to 0.
- R13: A copy's bits 1:0 take `wrData[1:0]` at the clock edge only when `wrEn` is high and the outcome selects that copy. Writes under a trap or undefined outcome change no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register copies |
| rst_n | input | 1 | Active-low asynchronous reset |
| accLevel | input | 2 | Privilege level of the access |
| lvl2En | input | 1 | Hypervisor level enabled |
| lvl3Present | input | 1 | Monitor level implemented |
| undefPrio | input | 1 | Monitor early-undefined condition |
| undefLate | input | 1 | Monitor late-undefined condition |
| irqRoute | input | 1 | Monitor IRQ routing bit |
| fiqRoute | input | 1 | Monitor FIQ routing bit |
| hypT12 | input | 1 | Hypervisor coarse trap bit |
| hypTc | input | 1 | Hypervisor control-register trap bit |
| hypFiqVirt | input | 1 | Hypervisor FIQ virtualisation bit |
| hypIrqVirt | input | 1 | Hypervisor IRQ virtualisation bit |
| sreL1 | input | 1 | Level-1 register-interface enable |
| sreL2 | input | 1 | Level-2 register-interface enable |
| sreL3 | input | 1 | Level-3 register-interface enable |
| nsState | input | 1 | Non-secure state at level 3 |
| wrEn | input | 1 | Access is a write |
| wrData | input | 32 | Write data |
| outcome | output | 7 | One-hot outcome |
| trapCode | output | 6 | Syndrome class for the hypervisor trap |
| rdData | output | 32 | Read data of the selected copy |

## Verification
The hard cases are the narrow gaps in the priority chain. A level-1 access with T12 set and the level-1 enable clear must trap, not come back undefined. An access with TC set and the level-1 enable clear must come back undefined. A further case needs the virtualisation bits set while the monitor has claimed both interrupts. All 65536 combinations of the level and the fourteen configuration bits are swept, so every such gap is reached. A separate write phase steers writes into each copy in turn and also issues writes under the trap and undefined outcomes. It then reads all four copies back to show that only the targeted copy moved.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int OUTCOME_W  = 7;
  localparam int NUM_COPIES = 4;
  localparam int FIRST_COPY = 3;
  localparam logic [5:0] HYP_TRAP_CODE = 6'h03;

  typedef enum logic [2:0] {
    OUT_UNDEF    = 3'd0,
    OUT_TRAP_HYP = 3'd1,
    OUT_TRAP_MON = 3'd2,
    OUT_VIRT     = 3'd3,
    OUT_NS       = 3'd4,
    OUT_SEC      = 3'd5,
    OUT_SINGLE   = 3'd6
  } outcome_e;

  typedef struct packed {
    logic [NUM_COPIES-1:0] rdHit;
    logic [NUM_COPIES-1:0] wrHit;
  } bank_strobe_t;
endpackage

// File: rtl/acr_decide.sv
module acr_decide
  import acr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           accLevel,
  input  logic                 lvl2En,
  input  logic                 lvl3Present,
  input  logic                 undefPrio,
  input  logic                 undefLate,
  input  logic                 irqRoute,
  input  logic                 fiqRoute,
  input  logic                 hypT12,
  input  logic                 hypTc,
  input  logic                 hypFiqVirt,
  input  logic                 hypIrqVirt,
  input  logic                 sreL1,
  input  logic                 sreL2,
  input  logic                 sreL3,
  input  logic                 nsState,
  input  logic                 wrEn,
  output logic [OUTCOME_W-1:0] outcome,
  output logic [5:0]           trapCode,
  output bank_strobe_t         strobe
);
  outcome_e sel;
  logic monClaims;
  logic earlyUndef;
  logic physCopy;

  assign monClaims  = lvl3Present && irqRoute && fiqRoute;
  assign earlyUndef = monClaims && undefPrio;
  assign physCopy   = lvl3Present ? 1'b1 : 1'b0;

  always_comb begin
    sel = OUT_UNDEF;
    unique case (accLevel)
      2'd0: sel = OUT_UNDEF;
      2'd1: begin
        if (earlyUndef)                              sel = OUT_UNDEF;
        else if (lvl2En && hypT12)                   sel = OUT_TRAP_HYP;
        else if (!sreL1)                             sel = OUT_UNDEF;
        else if (lvl2En && hypTc)                    sel = OUT_TRAP_HYP;
        else if (lvl2En && (hypFiqVirt || hypIrqVirt)) sel = OUT_VIRT;
        else if (monClaims)                          sel = undefLate ? OUT_UNDEF : OUT_TRAP_MON;
        else                                         sel = physCopy ? OUT_NS : OUT_SINGLE;
      end
      2'd2: begin
        if (earlyUndef)                              sel = OUT_UNDEF;
        else if (!sreL2)                             sel = OUT_UNDEF;
        else if (monClaims)                          sel = undefLate ? OUT_UNDEF : OUT_TRAP_MON;
        else                                         sel = physCopy ? OUT_NS : OUT_SINGLE;
      end
      default: begin
        if (!sreL3)                                  sel = OUT_UNDEF;
        else                                         sel = nsState ? OUT_NS : OUT_SEC;
      end
    endcase
  end

  assign outcome  = OUTCOME_W'(1) << sel;
  assign trapCode = (sel == OUT_TRAP_HYP) ? HYP_TRAP_CODE : 6'h00;

  always_comb begin
    for (int c = 0; c < NUM_COPIES; c++) begin
      strobe.rdHit[c] = outcome[FIRST_COPY + c];
      strobe.wrHit[c] = outcome[FIRST_COPY + c] && wrEn;
    end
  end

  assert_one_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(outcome) == 1);
  assert_lvl0_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accLevel == 2'd0) |-> outcome[0]);
  assert_trap_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trapCode == HYP_TRAP_CODE) == outcome[1]);
  assert_lvl3_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accLevel == 2'd3 && !sreL3) |-> outcome[0]);
  assert_write_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (strobe.wrHit == '0));
endmodule

// File: rtl/acr_bank.sv
module acr_bank
  import acr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          WR_BITS  = 2,
  parameter logic [31:0] FEATURES = 32'h000C_2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int RO_W = DATA_W - WR_BITS;
  localparam logic [RO_W-1:0] RO_VALUE = FEATURES[DATA_W-1:WR_BITS];

  logic [WR_BITS-1:0] ctlBits [NUM_COPIES];

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ctlBits[c] <= '0;
      else if (strobe.wrHit[c]) ctlBits[c] <= wrData[WR_BITS-1:0];
    end

    assert_hold_unselected_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.wrHit[c] |=> $stable(ctlBits[c]));
    assert_take_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.wrHit[c] |=> (ctlBits[c] == $past(wrData[WR_BITS-1:0])));
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_COPIES; c++)
      if (strobe.rdHit[c]) rdData = rdData | {RO_VALUE, ctlBits[c]};
  end

  assert_read_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdHit == '0) |-> (rdData == '0));
endmodule

// File: rtl/ctl_access_router.sv
module ctl_access_router
  import acr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          WR_BITS  = 2,
  parameter logic [31:0] FEATURES = 32'h000C_2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        accLevel,
  input  logic              lvl2En,
  input  logic              lvl3Present,
  input  logic              undefPrio,
  input  logic              undefLate,
  input  logic              irqRoute,
  input  logic              fiqRoute,
  input  logic              hypT12,
  input  logic              hypTc,
  input  logic              hypFiqVirt,
  input  logic              hypIrqVirt,
  input  logic              sreL1,
  input  logic              sreL2,
  input  logic              sreL3,
  input  logic              nsState,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [6:0]        outcome,
  output logic [5:0]        trapCode,
  output logic [DATA_W-1:0] rdData
);
  bank_strobe_t strobe;

  acr_decide u_decide (
    .clk(clk), .rst_n(rst_n), .accLevel(accLevel), .lvl2En(lvl2En),
    .lvl3Present(lvl3Present), .undefPrio(undefPrio), .undefLate(undefLate),
    .irqRoute(irqRoute), .fiqRoute(fiqRoute), .hypT12(hypT12), .hypTc(hypTc),
    .hypFiqVirt(hypFiqVirt), .hypIrqVirt(hypIrqVirt), .sreL1(sreL1),
    .sreL2(sreL2), .sreL3(sreL3), .nsState(nsState), .wrEn(wrEn),
    .outcome(outcome), .trapCode(trapCode), .strobe(strobe)
  );

  acr_bank #(.DATA_W(DATA_W), .WR_BITS(WR_BITS), .FEATURES(FEATURES)) u_bank (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/sim_ctl_access_router.sv
`timescale 1ns/1ps
module sim_ctl_access_router;
  localparam logic [31:0] FEAT = 32'h000C_2500;
  localparam logic [31:0] RO   = FEAT & ~32'h3;

  logic clk = 0, rst_n = 0;
  logic [1:0] accLevel = 0;
  logic lvl2En = 0, lvl3Present = 0, undefPrio = 0, undefLate = 0;
  logic irqRoute = 0, fiqRoute = 0, hypT12 = 0, hypTc = 0;
  logic hypFiqVirt = 0, hypIrqVirt = 0, sreL1 = 0, sreL2 = 0, sreL3 = 0, nsState = 0;
  logic wrEn = 0;
  logic [31:0] wrData = 0;
  logic [6:0] outcome;
  logic [5:0] trapCode;
  logic [31:0] rdData;

  int compared = 0, mismatched = 0;
  logic [1:0] model [4];

  always #2 clk = ~clk;

  ctl_access_router u0 (
    .clk(clk), .rst_n(rst_n), .accLevel(accLevel), .lvl2En(lvl2En),
    .lvl3Present(lvl3Present), .undefPrio(undefPrio), .undefLate(undefLate),
    .irqRoute(irqRoute), .fiqRoute(fiqRoute), .hypT12(hypT12), .hypTc(hypTc),
    .hypFiqVirt(hypFiqVirt), .hypIrqVirt(hypIrqVirt), .sreL1(sreL1),
    .sreL2(sreL2), .sreL3(sreL3), .nsState(nsState), .wrEn(wrEn),
    .wrData(wrData), .outcome(outcome), .trapCode(trapCode), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected outcome index and the requirement deciding it.
  function automatic int expect_sel(input logic [15:0] v, output string tag);
    logic [1:0] lv = v[1:0];
    logic l2 = v[2], l3 = v[3], up = v[4], ul = v[5], irq = v[6], fiq = v[7];
    logic t12 = v[8], tc = v[9], fmo = v[10], imo = v[11];
    logic s1 = v[12], s2 = v[13], s3 = v[14], ns = v[15];
    logic claim = l3 & irq & fiq;
    if (lv == 0) begin tag = "R1"; return 0; end
    if (lv == 3) begin
      tag = "R10";
      if (!s3) return 0;
      return ns ? 4 : 5;
    end
    if (claim && up) begin tag = "R3"; return 0; end
    if (lv == 1) begin
      if (l2 && t12) begin tag = "R4"; return 1; end
      if (!s1) begin tag = "R5"; return 0; end
      if (l2 && tc) begin tag = "R5"; return 1; end
      if (l2 && (fmo || imo)) begin tag = "R6"; return 3; end
    end else begin
      if (!s2) begin tag = "R9"; return 0; end
    end
    if (claim) begin tag = "R7"; return ul ? 0 : 2; end
    tag = "R8";
    return l3 ? 4 : 6;
  endfunction

  task automatic apply(input logic [15:0] v);
    accLevel = v[1:0]; lvl2En = v[2]; lvl3Present = v[3]; undefPrio = v[4];
    undefLate = v[5]; irqRoute = v[6]; fiqRoute = v[7]; hypT12 = v[8];
    hypTc = v[9]; hypFiqVirt = v[10]; hypIrqVirt = v[11]; sreL1 = v[12];
    sreL2 = v[13]; sreL3 = v[14]; nsState = v[15];
  endtask

  // Route encodings: 0 virtual, 1 non-secure, 2 secure, 3 single, 4 level-0 undef,
  // 5 hypervisor trap, 6 monitor trap.
  function automatic logic [15:0] route_vec(input int r);
    case (r)
      0: return 16'h1405;           // L1, l2En, FMO, sreL1
      1: return 16'hC003;           // L3, sreL3, ns=1
      2: return 16'h4003;           // L3, sreL3, ns=0
      3: return 16'h1001;           // L1, no L2/L3, sreL1
      4: return 16'h0000;           // L0
      5: return 16'h1105;           // L1, l2En, T12
      default: return 16'h10C9;     // L1, L3 claims, no late undef
    endcase
  endfunction

  task automatic read_all(input string tag);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      apply(route_vec(c));
      #1;
      check(tag, rdData, RO | {30'd0, model[c]});
    end
  endtask

  task automatic do_write(input int r, input logic [31:0] d);
    @(negedge clk);
    apply(route_vec(r));
    wrData = d; wrEn = 1;
    @(posedge clk);
    #1;
    wrEn = 0;
    if (r < 4) model[r] = d[1:0];
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    string tag;
    int es;
    for (int c = 0; c < 4; c++) model[c] = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // Reset state of every copy (R12).
    read_all("R12 reset");

    // Exhaustive decision sweep (R1..R11).
    for (int v = 0; v < 65536; v++) begin
      apply(16'(v));
      #1;
      es = expect_sel(16'(v), tag);
      check({tag, " outcome R2"}, {25'd0, outcome}, 32'(7'(1) << es));
      check({tag, " trapCode R11"}, {26'd0, trapCode}, (es == 1) ? 32'h3 : 32'h0);
      check({tag, " rdData R12"}, rdData,
            (es >= 3) ? (RO | {30'd0, model[es-3]}) : 32'h0);
    end

    // Writes to each copy, only bits 1:0 take effect (R13, R12).
    for (int c = 0; c < 4; c++) begin
      do_write(c, 32'hFFFF_FFFC | 32'(c + 1));
      read_all("R13 targeted write");
    end
    do_write(2, 32'h0000_0000);
    read_all("R13 clear one copy");

    // Writes under undefined and trap outcomes change nothing (R13).
    do_write(4, 32'hFFFF_FFFF);
    read_all("R13 write at level0");
    do_write(5, 32'h0000_0002);
    read_all("R13 write under hyp trap");
    do_write(6, 32'h0000_0001);
    read_all("R13 write under mon trap");

    // Read without write enable leaves copies unchanged (R13).
    @(negedge clk); apply(route_vec(1)); wrData = 32'h0; @(posedge clk); #1;
    read_all("R13 read only");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule